// File: doc/BRIEF.md
# Programmable Skew Clock Output Matrix

This block is a digital model of a clock fanout stage. A fast timing clock drives a free-running master phase counter, and the counter defines a nominal square wave whose period is `PER_CYC` fast cycles. One skew time unit is `TU_CYC` fast cycles. Four output pairs each take a two-digit three-level select code. The code picks one of nine functions for the pair: the nominal clock moved earlier or later by a signed number of time units, a divide-by-two or divide-by-four copy, or an inverted copy. The pairs do not all offer the same functions. Pairs 0 and 1 step in single units and offer skew only. Pairs 2 and 3 step in double units, and each of them trades its two extreme codes for divider or inverter functions.

A test input turns the timing path off. While it is active, the reference input drives every output through a short fixed pipeline. Skew settings are then ignored, but each pair still applies its own inversion, and the dividers count reference rising edges. Select inputs are expected to be strapped, so they are not synchronised.

Top module: `skew_clock_matrix`

## Requirements
- R1: Pair p takes its code from `sel_i[4p+3:4p]`. The high digit is in bits [4p+3:4p+2] and the low digit in bits [4p+1:4p]. Each digit encodes 00 as LOW, 01 as MID and 10 as HIGH, and 11 is read as MID. `q0_o[p]` always equals `q1_o[p]`.
- R2: With test inactive, a pair at code MID/MID gives the nominal clock. After reset is released, this clock is high from the first rising edge for `PER_CYC/2` cycles, then low for `PER_CYC/2` cycles, and repeats.
- R3: On pairs 0 and 1, the code index is 3*high+low (LOW=0, MID=1, HIGH=2), giving a skew of index-4 units. The output is the nominal clock delayed by skew*`TU_CYC` cycles, so a negative skew moves it earlier.
- R4: On pairs 2 and 3, indices 1 to 7 give a skew of 2*(index-4) units, applied in the same way as in R3.
- R5: Pair 2 gives divide-by-two at LOW/LOW and divide-by-four at HIGH/HIGH. Pair 3 gives divide-by-two at LOW/LOW. Nominal periods are numbered from 0 at reset. Divide-by-two is high in the odd-numbered periods, and divide-by-four is high in periods 2 and 3 mod 4.
- R6: The divide-by-two and divide-by-four outputs fall on the same cycle. Each divided rising edge coincides with a rising edge of a zero-skew output.
- R7: Pair 3 at HIGH/HIGH gives the inverse of the zero-skew nominal clock.
- R8: When `test_i` is not 00, skew-function outputs equal `ref_i` delayed by two cycles, whatever their skew, and the inverting function gives the inverse of that.
- R9: In test mode, the divider functions count the rising edges of `ref_i` seen since reset. Divide-by-two shows bit 0 of the count and divide-by-four shows bit 1, and both change in the same cycle as the skew outputs.
- R10: While `rst_ni` is low, all outputs are 0. On release, the phase and divider counts restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast timing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference input used in test mode |
| test_i | input | 2 | Three-level test select, 00 = normal operation |
| sel_i | input | 16 | Four 4-bit pair function codes |
| q0_o | output | 4 | First output of each pair |
| q1_o | output | 4 | Second output of each pair |

## Verification
The bench sweeps every skew code on every pair against a phase model counted from reset. This catches a swapped code digit, a wrong step size, or a skew sign that delays where it should advance. It pairs divide-by-two with divide-by-four to catch dividers whose falling edges do not line up, or whose rising edges drift away from the zero-skew edge. It also exercises codes that use the 11 digit value, so a decoder that treats 11 as HIGH shows a shifted phase. In test mode it toggles the reference with skew codes set, so a design that still applies skew, or counts divider edges from the phase counter, gives outputs that no longer follow the reference.

// File: rtl/skm_pkg.sv
package skm_pkg;
  localparam int NPAIR = 4;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {FN_SKEW, FN_DIV2, FN_DIV4, FN_INV} fn_e;

  typedef struct packed {
    fn_e                fn;
    logic signed [3:0]  units;
  } fn_cfg_t;

  // pair flavours: fine skew only, coarse with div4, coarse with invert
  localparam int KIND_FINE   = 0;
  localparam int KIND_C_DIV4 = 1;
  localparam int KIND_C_INV  = 2;

  function automatic int lvl_of(input logic [1:0] d);
    case (d)
      2'b00:   return 0;
      2'b10:   return 2;
      default: return 1;
    endcase
  endfunction

  function automatic fn_cfg_t decode_sel(input logic [3:0] sel, input int kind);
    fn_cfg_t c;
    int idx;
    idx = 3 * lvl_of(sel[3:2]) + lvl_of(sel[1:0]);
    c.fn = FN_SKEW;
    c.units = 4'sd0;
    if (kind == KIND_FINE) begin
      c.units = 4'(idx - 4);
    end else if (idx == 0) begin
      c.fn = FN_DIV2;
    end else if (idx == 8) begin
      c.fn = (kind == KIND_C_DIV4) ? FN_DIV4 : FN_INV;
    end else begin
      c.units = 4'(2 * (idx - 4));
    end
    return c;
  endfunction
endpackage

// File: rtl/skm_phase_gen.sv
module skm_phase_gen #(
  parameter int PER_CYC = 32,
  localparam int PH_W = $clog2(PER_CYC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] ph_o,
  output logic            wrap_o
);
  logic [PH_W-1:0] ph_q;

  assign wrap_o = (ph_q == PH_W'(PER_CYC - 1));
  assign ph_o   = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (wrap_o) ph_q <= '0;
    else             ph_q <= ph_q + PH_W'(1);
  end
endmodule

// File: rtl/skm_div_cnt.sv
module skm_div_cnt (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  output logic [1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= 2'b00;
    else if (tick_i) cnt_o <= cnt_o + 2'b01;
  end
endmodule

// File: rtl/skm_pair_out.sv
module skm_pair_out #(
  parameter int PER_CYC = 32,
  parameter int TU_CYC  = 2,
  parameter int KIND    = 0,
  localparam int PH_W = $clog2(PER_CYC),
  localparam int HALF = PER_CYC / 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [3:0]      sel_i,
  input  logic            test_i,
  input  logic            ref_q_i,
  input  logic [PH_W-1:0] ph_i,
  input  logic [1:0]      ncnt_i,
  input  logic [1:0]      tcnt_i,
  output logic            q_o
);
  import skm_pkg::*;

  fn_cfg_t cfg;
  int      pos;
  logic    src;
  logic    nxt;

  always_comb begin
    cfg = decode_sel(sel_i, KIND);
    // phase seen by this output: master phase minus the skew in cycles
    pos = int'(ph_i) - int'($signed(cfg.units)) * TU_CYC;
    if (pos < 0)             pos = pos + PER_CYC;
    else if (pos >= PER_CYC) pos = pos - PER_CYC;
    src = test_i ? ref_q_i : (pos < HALF);
    case (cfg.fn)
      FN_DIV2: nxt = test_i ? tcnt_i[0] : ncnt_i[0];
      FN_DIV4: nxt = test_i ? tcnt_i[1] : ncnt_i[1];
      FN_INV:  nxt = ~src;
      default: nxt = src;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/skew_clock_matrix.sv
module skew_clock_matrix #(
  parameter int PER_CYC = 32,
  parameter int TU_CYC  = 2
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   ref_i,
  input  logic [1:0]                             test_i,
  input  logic [skm_pkg::NPAIR*skm_pkg::SEL_W-1:0] sel_i,
  output logic [skm_pkg::NPAIR-1:0]              q0_o,
  output logic [skm_pkg::NPAIR-1:0]              q1_o
);
  import skm_pkg::*;

  localparam int PH_W = $clog2(PER_CYC);

  logic [PH_W-1:0] master_ph;
  logic            wrap;
  logic            ref_q;
  logic            ref_rise;
  logic            test_act;
  logic [1:0]      ncnt;
  logic [1:0]      tcnt;
  logic [NPAIR-1:0] q;

  assign test_act = (test_i != 2'b00);
  assign ref_rise = ref_i & ~ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= ref_i;
  end

  skm_phase_gen #(.PER_CYC(PER_CYC)) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ph_o  (master_ph),
    .wrap_o(wrap)
  );

  // normal-mode divider advances once per nominal period
  skm_div_cnt u_ndiv (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(wrap),
    .cnt_o (ncnt)
  );

  // test-mode divider advances on each reference rising edge
  skm_div_cnt u_tdiv (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(ref_rise),
    .cnt_o (tcnt)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int K = (p < 2) ? KIND_FINE : ((p == 2) ? KIND_C_DIV4 : KIND_C_INV);
    skm_pair_out #(.PER_CYC(PER_CYC), .TU_CYC(TU_CYC), .KIND(K)) u_pair (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (sel_i[p*SEL_W +: SEL_W]),
      .test_i (test_act),
      .ref_q_i(ref_q),
      .ph_i   (master_ph),
      .ncnt_i (ncnt),
      .tcnt_i (tcnt),
      .q_o    (q[p])
    );
  end

  assign q0_o = q;
  assign q1_o = q;
endmodule

// File: rtl/skm_matrix_chk.sv
module skm_matrix_chk #(
  parameter int PER_CYC = 32,
  parameter int TU_CYC  = 2,
  localparam int PH_W = $clog2(PER_CYC)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ref_i,
  input logic [1:0]      test_i,
  input logic [15:0]     sel_i,
  input logic [3:0]      q_i,
  input logic [PH_W-1:0] ph_i
);
  logic [1:0]  cyc;
  logic [15:0] sel_d1, sel_d2;
  logic [1:0]  tst_d1, tst_d2;
  logic        ref_d1, ref_d2;
  logic        nrm2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc <= 2'd0;
      sel_d1 <= '0; sel_d2 <= '0;
      tst_d1 <= '0; tst_d2 <= '0;
      ref_d1 <= 1'b0; ref_d2 <= 1'b0;
    end else begin
      cyc <= (cyc == 2'd3) ? 2'd3 : cyc + 2'd1;
      sel_d1 <= sel_i; sel_d2 <= sel_d1;
      tst_d1 <= test_i; tst_d2 <= tst_d1;
      ref_d1 <= ref_i; ref_d2 <= ref_d1;
    end
  end

  assign nrm2 = (cyc == 2'd3) && (tst_d1 == 2'b00) && (tst_d2 == 2'b00);

  p_zero_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nrm2 && $rose(q_i[0]) && sel_d1[3:0] == 4'b0101 && sel_d2[3:0] == 4'b0101)
      |-> ph_i == PH_W'(1));

  p_fine_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nrm2 && $rose(q_i[1]) && sel_d1[7:4] == 4'b1000 && sel_d2[7:4] == 4'b1000)
      |-> ph_i == PH_W'((2 * TU_CYC + 1) % PER_CYC));

  p_coarse_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nrm2 && $rose(q_i[2]) && sel_d1[11:8] == 4'b0110 && sel_d2[11:8] == 4'b0110)
      |-> ph_i == PH_W'((2 * TU_CYC + 1) % PER_CYC));

  p_div_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nrm2 && !$stable(q_i[2]) && sel_d1[11:8] == 4'b0000 && sel_d2[11:8] == 4'b0000)
      |-> ph_i == PH_W'(1));

  p_fall_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nrm2 && $fell(q_i[2]) && sel_d1[11:8] == 4'b1010 && sel_d2[11:8] == 4'b1010 &&
     sel_d1[15:12] == 4'b0000 && sel_d2[15:12] == 4'b0000)
      |-> $fell(q_i[3]));

  p_inv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3 && tst_d1 == 2'b00 && sel_d1[3:0] == 4'b0101 && sel_d1[15:12] == 4'b1010)
      |-> q_i[3] != q_i[0]);

  p_test_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3 && tst_d1 != 2'b00) |-> (q_i[0] == ref_d2 && q_i[1] == ref_d2));
endmodule

bind skew_clock_matrix skm_matrix_chk #(.PER_CYC(PER_CYC), .TU_CYC(TU_CYC)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .ref_i (ref_i),
  .test_i(test_i),
  .sel_i (sel_i),
  .q_i   (q0_o),
  .ph_i  (master_ph)
);

// File: tb/tb_skew_clock_matrix.sv
`timescale 1ns/1ps
module tb_skew_clock_matrix;
  localparam int PER  = 32;
  localparam int TU   = 2;
  localparam int HALF = PER / 2;
  localparam int NV   = 8;
  localparam logic [15:0] VEC [NV] = '{
    16'h5555, 16'h91A0, 16'h0042, 16'hAA86,
    16'hF3CF, 16'h6419, 16'h2855, 16'h0A75
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_r = 1'b0;
  logic [1:0]  tst = 2'b00;
  logic [15:0] sel = 16'h5555;
  logic [3:0]  q0, q1;

  int  ecount;
  int  checks = 0;
  int  errors = 0;
  int  rises = 0;
  bit  done = 1'b0;

  skew_clock_matrix #(.PER_CYC(PER), .TU_CYC(TU)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_r), .test_i(tst),
    .sel_i(sel), .q0_o(q0), .q1_o(q1)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  function automatic int lvl(input logic [1:0] d);
    return (d == 2'b00) ? 0 : ((d == 2'b10) ? 2 : 1);
  endfunction

  function automatic bit nom(input int m);
    int r;
    r = m % PER;
    if (r < 0) r = r + PER;
    return r < HALF;
  endfunction

  // n = edges since reset release minus one
  function automatic bit exp_norm(input int p, input logic [3:0] code, input int n);
    int idx, k;
    idx = 3 * lvl(code[3:2]) + lvl(code[1:0]);
    k = n / PER;
    if (p < 2) return nom(n - (idx - 4) * TU);
    if (idx == 0) return (k % 2) == 1;
    if (idx == 8) return (p == 2) ? (((k / 2) % 2) == 1) : !nom(n);
    return nom(n - 2 * (idx - 4) * TU);
  endfunction

  function automatic string tag_of(input int v, input int p, input logic [3:0] code);
    int idx;
    idx = 3 * lvl(code[3:2]) + lvl(code[1:0]);
    if (v == 0) return "R2";
    if (v == 4) return "R1";
    if (v == 7 && p >= 2) return "R6";
    if (p < 2) return "R3";
    if (idx == 0 || (idx == 8 && p == 2)) return "R5";
    if (idx == 8) return "R7";
    return "R4";
  endfunction

  task automatic chk(input bit got, input bit exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at t=%0t", req, what, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic drive_ref(input bit v);
    if (v && !ref_r) rises++;
    ref_r = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic test_checks(input string what);
    logic [3:0] code2, code3;
    code2 = sel[11:8];
    code3 = sel[15:12];
    chk(q0[0], ref_r, "R8", {what, " pair0 follows ref"});
    chk(q0[1], ref_r, "R8", {what, " pair1 follows ref"});
    if (code2 == 4'b1010) chk(q0[2], rises[1], "R9", {what, " pair2 div4"});
    else                  chk(q0[2], rises[0], "R9", {what, " pair2 div2"});
    if (code3 == 4'b1010) chk(q0[3], !ref_r, "R8", {what, " pair3 inverted"});
    else                  chk(q0[3], rises[0], "R9", {what, " pair3 div2"});
    chk(q1 == q0, 1'b1, "R1", {what, " pair outputs equal"});
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int highs;
    // reset state
    repeat (3) @(negedge clk);
    chk(q0 == 4'h0, 1'b1, "R10", "outputs low in reset");
    chk(q1 == 4'h0, 1'b1, "R10", "q1 low in reset");
    rst_n = 1'b1;

    // nominal clock duty and start phase
    highs = 0;
    for (int c = 1; c <= 2 * PER; c++) begin
      @(negedge clk);
      if (q0[0]) highs++;
      if (c == 1)        chk(q0[0], 1'b1, "R2", "high after first edge");
      if (c == HALF + 1) chk(q0[0], 1'b0, "R2", "low after half period");
    end
    chk(highs == PER, 1'b1, "R2", "50% duty over two periods");

    // table walk
    for (int v = 0; v < NV; v++) begin
      sel = VEC[v];
      for (int c = 0; c < 4 * PER; c++) begin
        @(negedge clk);
        for (int p = 0; p < 4; p++) begin
          chk(q0[p], exp_norm(p, sel[4*p +: 4], ecount - 1), tag_of(v, p, sel[4*p +: 4]),
              $sformatf("vec %0d pair %0d", v, p));
          chk(q1[p], q0[p], "R1", $sformatf("vec %0d pair %0d q1", v, p));
        end
      end
    end

    // test mode, skew ignored, div4 and invert
    tst = 2'b01;
    sel = 16'hAA09;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drive_ref(!ref_r);
      test_checks("test01");
    end
    tst = 2'b10;
    sel = 16'h0009;
    for (int i = 0; i < 6; i++) begin
      drive_ref(!ref_r);
      test_checks("test10");
    end
    tst = 2'b11;
    sel = 16'hAA09;
    for (int i = 0; i < 4; i++) begin
      drive_ref(!ref_r);
      test_checks("test11");
    end
    drive_ref(1'b0);
    tst = 2'b00;

    // reset mid-run restarts phase
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    sel = 16'h5555;
    repeat (2) @(negedge clk);
    chk(q0 == 4'h0, 1'b1, "R10", "outputs cleared by reset");
    rises = 0;
    rst_n = 1'b1;
    for (int c = 1; c <= 4 * PER; c++) begin
      @(negedge clk);
      chk(q0[0], nom(c - 1), "R10", "phase restarted after reset");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule